// File: doc/BRIEF.md
# Keyed Protection Register File

This block is a small CPU-bus peripheral for a cartridge copy-protection check. It sits on the 16-bit CPU address bus next to the program ROM decoder. It answers two 2 KB address windows. A write into the lower window (0x5000-0x57FF) loads an 8-bit key index. A write into the upper window (0x5800-0x5FFF) stores a byte into one of four protection slots. Address bits [1:0] pick the slot. The byte stored is the CPU data XORed with a key byte. That key byte comes from a fixed 256-entry table at the index loaded last. A read from the upper window returns the selected slot, so the guarded program can later execute those bytes.

The key table is a constant ROM computed inside the block, so no memory file is needed. Every bus cycle completes in one clock. The block cannot apply back-pressure, so the bus has no ready signal. A cycle is qualified by `cpu_strobe`. Writes take effect at the rising clock edge while the strobe is high. Read data is combinational in the same cycle. `rd_oe` tells the board-level bus mux when the block drives the data bus.

Top module: `prot_xor_regs`

## Requirements
- R1: After reset, the key index and all four slots are zero, so a read of any slot returns 0x00.
- R2: A strobed write anywhere in 0x5000-0x57FF loads `cpu_wdata` into the key index at that clock edge.
- R3: A strobed write anywhere in 0x5800-0x5FFF stores `cpu_wdata` XOR key[index] into the slot selected by address bits [1:0]. Address bits [10:2] are ignored.
- R4: A strobed read anywhere in 0x5800-0x5FFF sets `rd_oe` high and returns the slot selected by address bits [1:0] in the same cycle.
- R5: In every other case, `rd_oe` is low and `rd_data` is 0x00. This covers reads outside 0x5800-0x5FFF, writes, and cycles with no strobe.
- R6: A slot write leaves the key index unchanged, so several slot writes in a row use the same key.
- R7: Every key byte is a subset of 0x59; only bits 0, 3, 4 and 6 can be set.
- R8: Key entries at indices 0x00 through 0x08 all equal 0x59.
- R9: Key entries 0x40, 0x41, 0x42 and 0x43 are 0x00, 0x10, 0x40 and 0x50. Key entries 0x48 through 0x4F are 0x00.
- R10: Writes to addresses outside both windows change neither the index nor any slot.
- R11: Reads do not change the index or any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_strobe | input | 1 | Bus cycle valid this clock |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| rd_data | output | 8 | Read data, 0x00 when not driving |
| rd_oe | output | 1 | High while the block drives the data bus |

## Verification
The bench walks index, data and slot combinations drawn from every quadrant of the key table. It varies the ignored middle address bits on each access. A design that decoded too few address bits, or used the wrong table row, would store a wrong byte. The bench loads key index 0 with data 0x00 and reads all 256 keys back through slot 3. This exposes any key bit outside mask 0x59 and any wrong entry in the fixed index ranges. It also writes one slot several times without reloading the index, which catches a design that advances or clears the index on a slot write. Writes and reads just outside both windows (0x4FFF, 0x6000), and reads during writes, must leave the state and `rd_oe` untouched. A loose decoder would either corrupt a slot or drive the bus.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int KEY_DEPTH = 1 << BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [NUM_SLOTS-1:0][BYTE_W-1:0] slot_arr_t;

  typedef enum logic [1:0] {
    ACC_NONE    = 2'd0,
    ACC_IDX_WR  = 2'd1,
    ACC_SLOT_WR = 2'd2,
    ACC_SLOT_RD = 2'd3
  } acc_e;

  // Key generator. Index bits 6 and 3 select the quadrant behaviour;
  // bits 1, 0, 4 and 7 feed key bits 6, 4, 3 and 0 respectively.
  function automatic byte_t key_of(input byte_t i);
    byte_t v;
    byte_t k;
    v = '0;
    v[6] = i[1];
    v[4] = i[0];
    v[3] = i[4];
    v[0] = i[7];
    if (i[6]) k = i[3] ? 8'h00 : v;
    else      k = i[3] ? (~v & 8'h59) : 8'h59;
    return k;
  endfunction
endpackage

// File: rtl/prot_key_rom.sv
module prot_key_rom
  import prot_pkg::*;
(
  input  byte_t idx,
  output byte_t key
);
  byte_t rom [KEY_DEPTH];

  for (genvar g = 0; g < KEY_DEPTH; g++) begin : g_rom
    assign rom[g] = key_of(byte_t'(g));
  end

  assign key = rom[idx];
endmodule

// File: rtl/prot_addr_decode.sv
module prot_addr_decode
  import prot_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WIN_LSB = 11,
  parameter logic [ADDR_W-WIN_LSB-1:0] IDX_WIN  = 5'h0A,
  parameter logic [ADDR_W-WIN_LSB-1:0] SLOT_WIN = 5'h0B
) (
  input  logic              strobe,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  output acc_e              acc,
  output slot_t             slot
);
  localparam int WIN_W = ADDR_W - WIN_LSB;

  logic [WIN_W-1:0] win;
  logic             unused_mid;

  assign win        = addr[ADDR_W-1:WIN_LSB];
  assign slot       = addr[SLOT_W-1:0];
  assign unused_mid = ^addr[WIN_LSB-1:SLOT_W];

  always_comb begin
    acc = ACC_NONE;
    if (strobe) begin
      if (rw) begin
        if (win == SLOT_WIN) acc = ACC_SLOT_RD;
      end else begin
        if (win == IDX_WIN)       acc = ACC_IDX_WR;
        else if (win == SLOT_WIN) acc = ACC_SLOT_WR;
      end
    end
  end
endmodule

// File: rtl/prot_slot_file.sv
module prot_slot_file
  import prot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  acc_e      acc,
  input  slot_t     slot,
  input  byte_t     wdata,
  input  byte_t     key,
  output byte_t     idx_q,
  output slot_arr_t slots_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (acc == ACC_IDX_WR) idx_q <= wdata;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slots_q[s] <= '0;
      else if (acc == ACC_SLOT_WR && slot == slot_t'(s)) slots_q[s] <= wdata ^ key;
    end
  end
endmodule

// File: rtl/prot_xor_regs.sv
module prot_xor_regs
  import prot_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_strobe,
  input  logic              cpu_rw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        rd_data,
  output logic              rd_oe
);
  acc_e      acc;
  slot_t     slot;
  byte_t     idx_q;
  byte_t     key_byte;
  slot_arr_t slots_q;

  prot_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .strobe (cpu_strobe),
    .rw     (cpu_rw),
    .addr   (cpu_addr),
    .acc    (acc),
    .slot   (slot)
  );

  prot_key_rom u_rom (
    .idx (idx_q),
    .key (key_byte)
  );

  prot_slot_file u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .slot    (slot),
    .wdata   (cpu_wdata),
    .key     (key_byte),
    .idx_q   (idx_q),
    .slots_q (slots_q)
  );

  assign rd_oe   = (acc == ACC_SLOT_RD);
  assign rd_data = rd_oe ? slots_q[slot] : '0;
endmodule

// File: rtl/prot_xor_regs_chk.sv
module prot_xor_regs_chk
  import prot_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_strobe,
  input logic        cpu_rw,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic [7:0]  rd_data,
  input logic        rd_oe,
  input byte_t       idx_q,
  input byte_t       key_byte,
  input slot_arr_t   slots_q
);
  logic idx_wr, slot_wr, slot_rd;
  assign idx_wr  = cpu_strobe && !cpu_rw && cpu_addr[15:11] == 5'h0A;
  assign slot_wr = cpu_strobe && !cpu_rw && cpu_addr[15:11] == 5'h0B;
  assign slot_rd = cpu_strobe &&  cpu_rw && cpu_addr[15:11] == 5'h0B;

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> idx_q == $past(cpu_wdata)); // R2
  AST_SLOT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wr |=> slots_q[$past(cpu_addr[1:0])] == ($past(cpu_wdata) ^ $past(key_byte))); // R3
  AST_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_rd |-> rd_oe && rd_data == slots_q[cpu_addr[1:0]]); // R4
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_rd |-> !rd_oe && rd_data == 8'h00); // R5
  AST_IDX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wr |=> $stable(idx_q)); // R6
  AST_KEY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (key_byte & 8'hA6) == 8'h00); // R7
  AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_strobe && cpu_rw) |=> $stable(idx_q) && $stable(slots_q)); // R11
endmodule

bind prot_xor_regs prot_xor_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_strobe(cpu_strobe),
  .cpu_rw    (cpu_rw),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .rd_data   (rd_data),
  .rd_oe     (rd_oe),
  .idx_q     (idx_q),
  .key_byte  (key_byte),
  .slots_q   (slots_q)
);

// File: tb/prot_xor_regs_test.sv
module prot_xor_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_strobe = 1'b0;
  logic        cpu_rw = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  rd_data;
  logic        rd_oe;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  prot_xor_regs uut (
    .clk(clk), .rst_n(rst_n), .cpu_strobe(cpu_strobe), .cpu_rw(cpu_rw),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  // {index, data, expected, 6'b0, slot}; expected values worked by hand
  localparam int NVEC = 12;
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 8'h59, 8'h00}, {8'h41, 8'hFF, 8'hEF, 8'h01},
    {8'h4C, 8'hA5, 8'hA5, 8'h02}, {8'h09, 8'h49, 8'h00, 8'h03},
    {8'h18, 8'h0F, 8'h5E, 8'h00}, {8'h88, 8'h00, 8'h58, 8'h01},
    {8'hC5, 8'hF0, 8'hE1, 8'h02}, {8'hD3, 8'h59, 8'h00, 8'h03},
    {8'h9B, 8'h3C, 8'h3C, 8'h00}, {8'h53, 8'h01, 8'h59, 8'h01},
    {8'h2A, 8'h80, 8'h99, 8'h02}, {8'hFF, 8'h77, 8'h77, 8'h03}
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_strobe = 1'b1; cpu_rw = 1'b0; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_strobe = 1'b0; cpu_rw = 1'b1;
  endtask

  // returns {rd_oe, rd_data} sampled mid-cycle
  task automatic bus_read(input logic [15:0] a, output logic [8:0] r);
    @(negedge clk);
    cpu_strobe = 1'b1; cpu_rw = 1'b1; cpu_addr = a;
    #1 r = {rd_oe, rd_data};
    @(negedge clk);
    cpu_strobe = 1'b0;
  endtask

  initial begin : watchdog
    #400000;
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    logic [8:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int s = 0; s < 4; s++) begin
      bus_read(16'h5800 | 16'(s), r);
      check("R1 reset slot", r, 9'h100);
    end

    // R2, R3, R4: vector walk with varying ignored address bits
    for (int i = 0; i < NVEC; i++) begin
      bus_write(16'h5000 | 16'(i * 37), VEC[i][31:24]);
      bus_write(16'h5800 | 16'((i * 52) & 16'h07FC) | 16'(VEC[i][1:0]), VEC[i][23:16]);
      bus_read(16'h5FFC | 16'(VEC[i][1:0]), r);
      check("R3 R4 store/read", r, {1'b1, VEC[i][15:8]});
    end

    // R6: repeated slot writes reuse index 0x41 (key 0x10)
    bus_write(16'h57FF, 8'h41);
    bus_write(16'h5800, 8'h00);
    bus_write(16'h5801, 8'h10);
    bus_write(16'h5802, 8'h33);
    bus_read(16'h5800, r); check("R6 first", r, 9'h110);
    bus_read(16'h5801, r); check("R6 second", r, 9'h100);
    bus_read(16'h5802, r); check("R6 third", r, 9'h123);

    // R10: writes just outside the windows
    bus_write(16'h4FFF, 8'h00);
    bus_write(16'h6000, 8'hAA);
    bus_write(16'h6803, 8'hAA);
    bus_write(16'h5803, 8'h00);
    bus_read(16'h5800, r); check("R10 slot kept", r, 9'h110);
    bus_read(16'h5803, r); check("R10 index kept (key 0x10)", r, 9'h110);

    // R5: no drive outside window or when idle or writing
    bus_read(16'h57FF, r); check("R5 read idx window", r, 9'h000);
    bus_read(16'h6000, r); check("R5 read above", r, 9'h000);
    @(negedge clk);
    cpu_strobe = 1'b1; cpu_rw = 1'b0; cpu_addr = 16'h4123; cpu_wdata = 8'h00;
    #1 check("R5 during write", {rd_oe, rd_data}, 9'h000);
    @(negedge clk);
    cpu_strobe = 1'b0; cpu_rw = 1'b1; cpu_addr = 16'h5800;
    #1 check("R5 no strobe", {rd_oe, rd_data}, 9'h000);

    // R11: reads leave state alone
    for (int k = 0; k < 3; k++) bus_read(16'h5802, r);
    check("R11 repeated read", r, 9'h123);

    // R7, R8, R9: key sweep through slot 3 with data 0
    for (int i = 0; i < 256; i++) begin
      bus_write(16'h5000, 8'(i));
      bus_write(16'h5803, 8'h00);
      bus_read(16'h5803, r);
      check("R7 key mask", {1'b0, r[7:0] & 8'hA6}, 9'h000);
      if (i <= 8) check("R8 low keys", r, 9'h159);
      if (i == 8'h40) check("R9 key 40", r, 9'h100);
      if (i == 8'h41) check("R9 key 41", r, 9'h110);
      if (i == 8'h42) check("R9 key 42", r, 9'h140);
      if (i == 8'h43) check("R9 key 43", r, 9'h150);
      if (i >= 8'h48 && i <= 8'h4F) check("R9 zero keys", r, 9'h100);
    end

    // R1: reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    bus_write(16'h5803, 8'h00);
    bus_read(16'h5803, r); check("R1 index cleared (key 0x59)", r, 9'h159);
    bus_read(16'h5802, r); check("R1 slot cleared", r, 9'h100);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule